// File: doc/BRIEF.md
# Predicated Tree Reduction Scheduler

This block produces a fixed, repeatable schedule for a pairwise tree reduction over a vector of up to `N` elements, under a predicate mask. Each step names two element indices. An external execution unit combines them as `dst = op(dst, src)`. The operator and the register file are not part of this block. Steps leave one at a time through a valid/ready handshake.

Elements are never moved. A masked-out lane is bridged by repointing a slot of an internal index-redirection table, and an internal working copy of the predicate tracks which slots hold a live value. The caller's mask is sampled once, at start, and is not used after that. When the last level is finished, the block raises `done` and reports the element index that holds the final result. That index is the lowest active element.

The schedule depends only on the vector length, the mask and the position inside the walk. Software can therefore rebuild the internal state from the element position after an interruption.

Top module: `tr_sched`

## Requirements
- R1: While reset is held and in the cycle after it is released, `step_valid` and `done` are both 0.
- R2: A `start` pulse is accepted only when the block is not running. When accepted, it samples `vl` and `mask`, and a `vl` above `N` is clamped to `N`. A `start` pulse during a run is ignored. Changes to `vl` or `mask` after the accepting edge have no effect on the schedule or the result.
- R3: The walk goes level by level. The half-stride `h` starts at 1 and doubles while `h < VL`. Within a level, the lower slots `i = 0, 2h, 4h, ...` below VL are evaluated in ascending order, one slot per cycle unless a step is stalled. The partner of slot `i` is `i + h`.
- R4: When both the slot and its partner are active, a step is offered. `step_dst` is the slot's redirected index and `step_src` is the partner's redirected index. The slot then counts as holding the combined value.
- R5: When only the partner is active, no step is offered. The slot is redirected to the partner's index and marked active, and this takes one cycle.
- R6: A partner whose index is VL or above counts as inactive.
- R7: If no mask bit below VL is set (this includes VL = 0), no step is offered. In that case `done` is 1 in the cycle after the accepting edge, with `no_result` = 1 and `result_idx` = 0.
- R8: After the cycle that evaluates the last slot, `done` stays 1 and `step_valid` stays 0 until the next accepted `start`. During that time `result_idx` equals the index of the lowest active element below VL.
- R9: While `step_valid` is 1 and `step_ready` is 0, the offered step is held unchanged into the next cycle.
- R10: Every offered step has `step_dst < step_src`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new schedule (accepted when not running) |
| vl | input | $clog2(N+1) | Vector length, clamped to N |
| mask | input | N | Predicate, bit k enables element k |
| step_valid | output | 1 | A step is offered |
| step_ready | input | 1 | The execution unit takes the offered step |
| step_dst | output | $clog2(N) | Element index that receives the result |
| step_src | output | $clog2(N) | Element index that is combined in |
| done | output | 1 | Schedule finished, result index valid |
| no_result | output | 1 | No active element existed |
| result_idx | output | $clog2(N) | Element that holds the reduced value |

## Verification
The first slot is evaluated in the first cycle after the edge that accepts `start`. Each later slot takes exactly one more cycle, plus one cycle for every cycle a step waits on `step_ready`. `done` therefore appears in the cycle after the last slot, and when no lane is active it appears in the first cycle after the accepting edge. The reference model in the bench holds a queue with one entry per slot evaluation. On each falling edge it compares the outputs with the front entry and pops that entry only when the design would advance. Because of this, a step that comes early, late or with the wrong value is seen in the exact cycle where it happens.

// File: rtl/tr_pkg.sv
package tr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } tr_state_e;
endpackage

// File: rtl/tr_walker.sv
// Level/slot walker: tracks the current lower slot and the half-stride.
module tr_walker #(
  parameter int N = 16,
  localparam int LW = $clog2(N + 1),
  localparam int CW = LW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic [LW-1:0] vl_q,
  output logic [CW-1:0] pos,
  output logic [CW-1:0] other,
  output logic          last
);
  logic [CW-1:0] pos_q, pos_d, half_q, half_d;
  logic [CW-1:0] npos, nhalf, vlx;
  logic          more_pairs, en;

  always_comb begin
    vlx        = CW'(vl_q);
    npos       = pos_q + (half_q << 1);
    nhalf      = half_q << 1;
    more_pairs = npos < vlx;
    last       = !more_pairs && (nhalf >= vlx);
    pos        = pos_q;
    other      = pos_q + half_q;
    en         = load | adv;
    pos_d      = pos_q;
    half_d     = half_q;
    if (load) begin
      pos_d  = '0;
      half_d = CW'(1);
    end else if (more_pairs) begin
      pos_d  = npos;
    end else begin
      pos_d  = '0;
      half_d = nhalf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      half_q <= CW'(1);
    end else if (en) begin
      pos_q  <= pos_d;
      half_q <= half_d;
    end
  end
endmodule

// File: rtl/tr_redirect.sv
// Index-redirection table plus working predicate copy.
module tr_redirect #(
  parameter int N = 16,
  localparam int IW = $clog2(N),
  localparam int LW = $clog2(N + 1),
  localparam int CW = LW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [N-1:0]  mask,
  input  logic          redir,
  input  logic [CW-1:0] pos,
  input  logic [CW-1:0] other,
  input  logic [LW-1:0] vl_q,
  output logic [IW-1:0] dst_idx,
  output logic [IW-1:0] src_idx,
  output logic          a_act,
  output logic          b_act,
  output logic [IW-1:0] head_idx
);
  logic [IW-1:0] ix_q [N];
  logic [IW-1:0] ix_d [N];
  logic [N-1:0]  wp_q, wp_d;
  logic [N-1:0]  en;
  logic [IW-1:0] pi, oi;

  assign pi       = pos[IW-1:0];
  assign oi       = other[IW-1:0];
  assign dst_idx  = ix_q[pi];
  assign src_idx  = ix_q[oi];
  assign a_act    = wp_q[pi];
  assign b_act    = (other < CW'(vl_q)) && wp_q[oi];
  assign head_idx = ix_q[0];

  for (genvar k = 0; k < N; k++) begin : g_slot
    always_comb begin
      en[k]   = load | (redir && (pi == IW'(k)));
      ix_d[k] = load ? IW'(k) : ix_q[oi];
      wp_d[k] = load ? mask[k] : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ix_q[k] <= IW'(k);
        wp_q[k] <= 1'b0;
      end else if (en[k]) begin
        ix_q[k] <= ix_d[k];
        wp_q[k] <= wp_d[k];
      end
    end
  end
endmodule

// File: rtl/tr_sched.sv
module tr_sched #(
  parameter int N = 16,
  localparam int IW = $clog2(N),
  localparam int LW = $clog2(N + 1),
  localparam int CW = LW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] vl,
  input  logic [N-1:0]  mask,
  output logic          step_valid,
  input  logic          step_ready,
  output logic [IW-1:0] step_dst,
  output logic [IW-1:0] step_src,
  output logic          done,
  output logic          no_result,
  output logic [IW-1:0] result_idx
);
  import tr_pkg::*;

  tr_state_e     state_q, state_d;
  logic [LW-1:0] vl_q, vl_eff;
  logic          none_q;
  logic [N-1:0]  act_in;
  logic          any_act, accept, run, pair, adv, redir, last;
  logic [CW-1:0] pos, other;
  logic          a_act, b_act;
  logic [IW-1:0] head_idx;

  always_comb begin
    vl_eff = (vl > LW'(N)) ? LW'(N) : vl;
    for (int k = 0; k < N; k++) act_in[k] = mask[k] && (LW'(k) < vl_eff);
    any_act = |act_in;
    accept  = start && (state_q != ST_RUN);
    run     = (state_q == ST_RUN);
    pair    = a_act && b_act;
    adv     = run && (!pair || step_ready);
    redir   = run && !a_act && b_act;
    state_d = state_q;
    if (accept)           state_d = (any_act && vl_eff > LW'(1)) ? ST_RUN : ST_DONE;
    else if (adv && last) state_d = ST_DONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vl_q    <= '0;
      none_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        vl_q   <= vl_eff;
        none_q <= !any_act;
      end
    end
  end

  tr_walker #(.N(N)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(accept), .adv(adv), .vl_q(vl_q),
    .pos(pos), .other(other), .last(last)
  );

  tr_redirect #(.N(N)) u_redir (
    .clk(clk), .rst_n(rst_n), .load(accept), .mask(mask), .redir(redir),
    .pos(pos), .other(other), .vl_q(vl_q),
    .dst_idx(step_dst), .src_idx(step_src), .a_act(a_act), .b_act(b_act),
    .head_idx(head_idx)
  );

  assign step_valid = run && pair;
  assign done       = (state_q == ST_DONE);
  assign no_result  = none_q;
  assign result_idx = none_q ? '0 : head_idx;
endmodule

// File: rtl/tr_sched_chk.sv
module tr_sched_chk #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          step_valid,
  input logic          step_ready,
  input logic [IW-1:0] step_dst,
  input logic [IW-1:0] step_src,
  input logic          done,
  input logic          no_result,
  input logic [IW-1:0] result_idx
);
  p_step_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && !step_ready |=> step_valid && $stable(step_dst) && $stable(step_src));

  p_dst_below_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid |-> step_dst < step_src);

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !step_valid);

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(result_idx) && $stable(no_result));

  p_empty_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && no_result |-> result_idx == '0);
endmodule

bind tr_sched tr_sched_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .step_valid(step_valid),
  .step_ready(step_ready), .step_dst(step_dst), .step_src(step_src),
  .done(done), .no_result(no_result), .result_idx(result_idx)
);

// File: tb/tb_tr_sched.sv
`timescale 1ns/1ps
module tb_tr_sched;
  localparam int N = 16;
  localparam int IW = $clog2(N);
  localparam int LW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [LW-1:0] vl;
  logic [N-1:0]  mask;
  logic          step_valid, step_ready, done, no_result;
  logic [IW-1:0] step_dst, step_src, result_idx;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  tr_sched #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .mask(mask),
    .step_valid(step_valid), .step_ready(step_ready),
    .step_dst(step_dst), .step_src(step_src),
    .done(done), .no_result(no_result), .result_idx(result_idx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Reference: one queue entry per slot evaluation; kind 1 = step offered.
  task automatic run_case(input int vlv, input logic [N-1:0] m, input int rmode,
                          input logic [N-1:0] m_after, input bit inject);
    int q_kind[$], q_dst[$], q_src[$];
    int wp[N], ix[N];
    int vle, any, exp_res, n;
    bit r;
    vle = (vlv > N) ? N : vlv;
    any = 0;
    for (int k = 0; k < N; k++) begin
      wp[k] = m[k];
      ix[k] = k;
      if (k < vle && m[k]) any = 1;
    end
    if (any != 0 && vle >= 2) begin
      for (int h = 1; h < vle; h = h * 2) begin
        for (int i = 0; i < vle; i = i + 2 * h) begin
          int o;
          bit ob;
          o  = i + h;
          ob = (o < vle) && (wp[o] != 0);
          if (wp[i] != 0 && ob) begin
            q_kind.push_back(1); q_dst.push_back(ix[i]); q_src.push_back(ix[o]);
          end else begin
            if (ob) begin ix[i] = ix[o]; wp[i] = 1; end
            q_kind.push_back(0); q_dst.push_back(0); q_src.push_back(0);
          end
        end
      end
    end
    exp_res = (any != 0) ? ix[0] : 0;

    @(negedge clk);
    vl = LW'(vlv); mask = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0; mask = m_after; vl = LW'(3);   // R2: late input changes
    n = 1;
    while (n < 300) begin
      r = (rmode == 0) ? 1'b1 : (rmode == 1) ? n[0] : (n % 3 == 0);
      step_ready = r;
      if (inject && n == 2) begin vl = LW'(5); mask = '1; start = 1'b1; end   // R2
      if (inject && n == 3) start = 1'b0;
      if (q_kind.size() != 0) begin
        chk(done == 1'b0, "R3 done early", done, 0);
        if (q_kind[0] == 1) begin
          chk(step_valid == 1'b1, "R4 valid", step_valid, 1);
          chk(step_dst == IW'(q_dst[0]), r ? "R4 dst" : "R9 dst held", step_dst, q_dst[0]);
          chk(step_src == IW'(q_src[0]), r ? "R4 src" : "R9 src held", step_src, q_src[0]);
          chk(step_dst < step_src, "R10 order", step_dst, step_src);
          if (r) begin void'(q_kind.pop_front()); void'(q_dst.pop_front()); void'(q_src.pop_front()); end
        end else begin
          chk(step_valid == 1'b0, "R5 R6 no step", step_valid, 0);
          void'(q_kind.pop_front()); void'(q_dst.pop_front()); void'(q_src.pop_front());
        end
      end else begin
        chk(done == 1'b1, (any != 0) ? "R8 done" : "R7 done", done, 1);
        chk(step_valid == 1'b0, "R8 quiet", step_valid, 0);
        chk(no_result == (any == 0), "R7 no_result", no_result, any == 0);
        chk(result_idx == IW'(exp_res), "R8 result", result_idx, exp_res);
        break;
      end
      @(negedge clk);
      n++;
    end
    if (inject) start = 1'b0;
    repeat (2) @(negedge clk);
    chk(done == 1'b1 && result_idx == IW'(exp_res), "R8 held", result_idx, exp_res);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; vl = '0; mask = '0; step_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(step_valid == 1'b0, "R1 valid in reset", step_valid, 0);
    chk(done == 1'b0, "R1 done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(step_valid == 1'b0 && done == 1'b0, "R1 after release", done, 0);

    run_case(8,  16'h00ff, 0, 16'h0000, 1'b0);
    run_case(8,  16'h0096, 1, 16'hffff, 1'b0);
    run_case(16, 16'hffff, 2, 16'h0000, 1'b0);
    run_case(5,  16'h001a, 0, 16'h0000, 1'b0);   // R6 partner past VL
    run_case(16, 16'h8000, 1, 16'h0001, 1'b0);   // R5 redirect chain
    run_case(0,  16'hffff, 0, 16'h0000, 1'b0);   // R7 VL zero
    run_case(6,  16'h0000, 0, 16'hffff, 1'b0);   // R7 empty mask
    run_case(4,  16'h00f0, 0, 16'h0000, 1'b0);   // R7 active only past VL
    run_case(1,  16'h0001, 0, 16'h0000, 1'b0);
    run_case(7,  16'h0055, 2, 16'h0000, 1'b1);   // R2 ignored start, late mask
    run_case(20, 16'h0006, 0, 16'h0000, 1'b0);   // R2 clamp
    run_case(13, 16'h1248, 1, 16'h0000, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule